// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synchronous static memory with a registered command stage and a registered output. A command is sampled on a rising clock edge. Read data and write data both use the bus slot that follows the second active edge after the command. Because both directions have the same lag, a host can issue reads and writes in any order on consecutive cycles and never leave an idle cycle on the data bus. Write data arrives two active edges after its address, so the block holds each write's address, byte enables and abort state in a two-stage pipeline. A read issued while a write is still pending sees the pending bytes.

Each start command may continue as a four-beat burst. An internal sub-block generates the burst addresses, in either linear or interleaved order. A clock-enable input freezes the whole pipeline. An asynchronous output enable gates the read data. A sleep request idles the block while it keeps its contents.

Top module: `zt_pipe_sram`

## Requirements
- R1: A new operation starts only on a rising edge where clk_en_n=0, adv=0 and all three selects are active (sel1_n=0, sel2=1, sel3_n=0). On that edge addr and we_n are sampled, and we_n=0 means write.
- R2: On an edge with clk_en_n=1, every input is ignored and all pipeline and output state holds. If read data is being driven, it stays on rdata.
- R3: For a write started at edge E, the byte lanes with bw_n[i]=0 are stored from wdata[8*i+7:8*i] at the second active edge after E.
- R4: For a read started at edge E, the stored word appears on rdata after the second active edge after E. rdata_en is high for that cycle when oe_n=0.
- R5: A write beat with all bw_n bits high is an abort and leaves memory unchanged.
- R6: With adv=1 after a selected start, the operation continues with the same read or write type on the next burst address. Only the low two address bits change. They follow (start+k) mod 4 when interleave=0 and start XOR k when interleave=1, for beat k. The sequence wraps after four beats.
- R7: adv=0 with any select inactive deselects the block, so no operation takes place. adv=1 after a deselect or after reset also does nothing.
- R8: oe_n acts without a clock. oe_n=1 forces rdata_en low at once, while the read still runs as a dummy read.
- R9: If sleep is sampled high at edge S, inputs are ignored from edge S+2 on and rdata_en stays low while asleep. If sleep is sampled low at edge W, inputs are sampled again from edge W+2. Memory contents survive.
- R10: A read issued one cycle after a write to the same address returns the new bytes of that write, merged per lane with the older stored bytes.
- R11: Any mix of reads, writes, bursts and stalls issued back to back returns, for each read, the value given by all writes issued before it.
- R12: After reset, rdata_en is low and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| adv | input | 1 | 0 loads a new address, 1 continues the burst |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| we_n | input | 1 | Write enable, active low, sampled at a start |
| bw_n | input | LANES | Byte write strobes, active low, one per lane |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, taken two active edges after its command |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | LANES*LANE_W | Read data |
| rdata_en | output | 1 | High when rdata is driven onto the bus |

## Verification
A write pipeline slot that is wrongly shifted or lost shows as a stale or corrupted word. That word appears on the first later read of that address, which can be as soon as two cycles after the read is issued. Forwarding is the most likely fault, and it shows only when a read directly follows a write to the same address. For that reason the bench runs such pairs with partial byte masks. A burst counter in the wrong state shows as data from a neighbouring address within four beats. A frozen or leaky stall or sleep shows as rdata_en or rdata changing on an edge that should have been ignored.

// File: rtl/zt_pkg.sv
package zt_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen #(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
    } bg_t;

    bg_t bg_d, bg_q;
    logic [BURST_W-1:0] low_lin, low_ilv, low_sel;

    always_comb begin
        low_lin = bg_q.base[BURST_W-1:0] + bg_q.cnt;
        low_ilv = bg_q.base[BURST_W-1:0] ^ bg_q.cnt;
        low_sel = interleave ? low_ilv : low_lin;
        bg_d    = bg_q;
        if (load) begin
            cur_addr  = addr_in;
            bg_d.base = addr_in;
            bg_d.cnt  = BURST_W'(1);
        end else begin
            cur_addr = {bg_q.base[ADDR_W-1:BURST_W], low_sel};
            if (step) begin
                bg_d.cnt = bg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_q <= '0;
        end else if (load || step) begin
            bg_q <= bg_d;
        end
    end

    // R6: after a full set of beats the sequence returns to its start word
    assert_burst_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && bg_q.cnt == '0) |-> (cur_addr == bg_q.base));
endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;
    logic              same_addr;

    assign same_addr = wr_en && (wr_addr == rd_addr);

    // per-lane bypass of the write that commits on the same edge as the read
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_d[g*LANE_W +: LANE_W] = (same_addr && wr_be[g])
            ? wr_data[g*LANE_W +: LANE_W]
            : mem[rd_addr][g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_be[i]) begin
                    mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    // R5: an aborted beat never reaches the array
    assert_abort_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be != '0));

    // R10: a full-word write seen by a same-edge read is returned whole
    assert_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && same_addr && wr_be == '1) |=> (rd_q == $past(wr_data)));
endmodule

// File: rtl/zt_pipe_sram.sv
module zt_pipe_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LANES   = 2,
    parameter int LANE_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    adv,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    interleave,
    input  logic                    oe_n,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
    } slot_t;

    typedef struct packed {
        op_e               op;
        slot_t             s1;
        slot_t             s2;
        logic              out_vld;
        logic [DATA_W-1:0] dout;
        logic [1:0]        nap;
    } st_t;

    st_t st_d, st_q;

    logic              awake, en, selected, start, cont;
    logic [ADDR_W-1:0] beat_addr;
    logic              mem_wr_en, mem_rd_en;
    logic [DATA_W-1:0] mem_rd_data;

    assign awake    = ~st_q.nap[1];
    assign en       = ~clk_en_n & awake;
    assign selected = ~sel1_n & sel2 & ~sel3_n;
    assign start    = en & ~adv & selected;
    assign cont     = en & adv & (st_q.op != OP_IDLE);

    zt_burst_gen #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .step       (cont),
        .interleave (interleave),
        .addr_in    (addr),
        .cur_addr   (beat_addr)
    );

    assign mem_rd_en = en & st_q.s1.vld & ~st_q.s1.wr;
    assign mem_wr_en = en & st_q.s2.vld & st_q.s2.wr & (|st_q.s2.be);

    zt_mem_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_wr_en),
        .wr_addr (st_q.s2.addr),
        .wr_be   (st_q.s2.be),
        .wr_data (wdata),
        .rd_en   (mem_rd_en),
        .rd_addr (st_q.s1.addr),
        .rd_data (mem_rd_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.nap = {st_q.nap[0], sleep};
        if (en) begin
            st_d.s1 = '0;
            if (start) begin
                st_d.s1.vld  = 1'b1;
                st_d.s1.wr   = ~we_n;
                st_d.s1.addr = beat_addr;
                st_d.s1.be   = ~bw_n;
                st_d.op      = we_n ? OP_READ : OP_WRITE;
            end else if (cont) begin
                st_d.s1.vld  = 1'b1;
                st_d.s1.wr   = (st_q.op == OP_WRITE);
                st_d.s1.addr = beat_addr;
                st_d.s1.be   = ~bw_n;
            end else if (!adv) begin
                st_d.op = OP_IDLE;
            end
            st_d.s2      = st_q.s1;
            st_d.out_vld = st_q.s2.vld & ~st_q.s2.wr;
            if (st_q.s2.vld && !st_q.s2.wr) begin
                st_d.dout = mem_rd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.dout;
    assign rdata_en = st_q.out_vld & ~oe_n & ~st_q.nap[1];

    // R2: a disabled clock edge changes no pipeline or output state
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(st_q.s1) && $stable(st_q.s2)
                      && $stable(st_q.out_vld) && $stable(st_q.dout)));

    // R3: a command moves to the data stage on the next active edge
    assert_pipe_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.s1.vld) |=> (st_q.s2.vld && st_q.s2.addr == $past(st_q.s1.addr)));

    // R7: a deselect issues nothing
    assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv && !selected) |=> !st_q.s1.vld);

    // R9: while asleep the command pipeline is frozen
    assert_sleep_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nap[1] |=> ($stable(st_q.s1) && $stable(st_q.s2)));
endmodule

// File: tb/zt_pipe_sram_tb.sv
`timescale 1ns/1ps
module zt_pipe_sram_tb;
    localparam int AW = 6;
    localparam int LN = 2;
    localparam int DW = 16;
    localparam logic [2:0] SEL_ON = 3'b010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          ce_n = 1'b0, adv = 1'b0, s1n = 1'b1, s2 = 1'b0, s3n = 1'b1;
    logic          we_n = 1'b1, ilv = 1'b0, oe_n = 1'b0, slp = 1'b0;
    logic [LN-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    zt_pipe_sram u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(ce_n), .adv(adv),
        .sel1_n(s1n), .sel2(s2), .sel3_n(s3n), .we_n(we_n), .bw_n(bw_n),
        .addr(addr), .wdata(wdata), .interleave(ilv), .oe_n(oe_n),
        .sleep(slp), .rdata(rdata), .rdata_en(rdata_en)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [DW-1:0] ref_mem [64];
    logic          p1_v = 0, p1_w = 0, p2_v = 0, p2_w = 0;
    logic [AW-1:0] p1_a = 0, p2_a = 0;
    logic [LN-1:0] p1_be = 0, p2_be = 0;
    logic          out_v = 0;
    logic [DW-1:0] out_d = 0;
    int            mop = 0;
    logic [AW-1:0] b_base = 0;
    logic [1:0]    b_k = 0;
    logic          nap0 = 0, nap1 = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_out(input string tag);
        logic e_en;
        e_en = out_v && !oe_n && !nap1;
        check(tag, "rdata_en", {31'd0, rdata_en}, {31'd0, e_en});
        if (e_en) check(tag, "rdata", {16'd0, rdata}, {16'd0, out_d});
    endtask

    task automatic step(input string tag);
        logic          en_e, sel, st, ct, nv, nw;
        logic [AW-1:0] ia;
        logic [1:0]    low;
        en_e = !ce_n && !nap1;
        sel  = !s1n && s2 && !s3n;
        if (en_e) begin
            if (p2_v && p2_w)
                for (int i = 0; i < LN; i++)
                    if (p2_be[i]) ref_mem[p2_a][i*8 +: 8] = wdata[i*8 +: 8];
            out_v = p2_v && !p2_w;
            if (out_v) out_d = ref_mem[p2_a];
            st = !adv && sel;
            ct = adv && (mop != 0);
            nv = 0; nw = 0; ia = '0;
            if (st) begin
                ia = addr; b_base = addr; b_k = 2'd1;
                mop = we_n ? 1 : 2;
                nv = 1; nw = !we_n;
            end else if (ct) begin
                low = ilv ? (b_base[1:0] ^ b_k) : (b_base[1:0] + b_k);
                ia = {b_base[AW-1:2], low};
                b_k = b_k + 2'd1;
                nv = 1; nw = (mop == 2);
            end else if (!adv) begin
                mop = 0;
            end
            p2_v = p1_v; p2_w = p1_w; p2_a = p1_a; p2_be = p1_be;
            p1_v = nv; p1_w = nw; p1_a = ia; p1_be = ~bw_n;
        end
        nap1 = nap0;
        nap0 = slp;
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic go(input logic a_adv, input logic [2:0] a_sel, input logic a_wr,
                      input logic [AW-1:0] a_addr, input logic [LN-1:0] a_bw,
                      input string tag);
        adv = a_adv;
        {s1n, s2, s3n} = a_sel;
        we_n = !a_wr;
        addr = a_addr;
        bw_n = a_bw;
        wdata = DW'($urandom);
        step(tag);
    endtask

    task automatic flush(input string tag);
        for (int i = 0; i < 3; i++) go(1'b0, 3'b110, 1'b0, '0, '1, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "rdata_en in reset", {31'd0, rdata_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "rdata_en after reset", {31'd0, rdata_en}, 32'd0);

        // R7: continue after reset does nothing, then deselect then continue
        go(1'b1, SEL_ON, 1'b0, 6'd5, 2'b00, "R7");
        go(1'b0, 3'b110, 1'b0, 6'd5, 2'b00, "R7");
        go(1'b1, SEL_ON, 1'b0, 6'd5, 2'b00, "R7");
        flush("R7");

        // R3: fill every word back to back
        for (int a = 0; a < 64; a++) go(1'b0, SEL_ON, 1'b1, AW'(a), 2'b00, "R3");
        flush("R3");
        // R4: read every word back to back
        for (int a = 0; a < 64; a++) go(1'b0, SEL_ON, 1'b0, AW'(a), 2'b00, "R4");
        flush("R4");

        // R1: each inactive select blocks a write; readback unchanged
        go(1'b0, 3'b110, 1'b1, 6'd9, 2'b00, "R1");
        go(1'b0, 3'b000, 1'b1, 6'd9, 2'b00, "R1");
        go(1'b0, 3'b011, 1'b1, 6'd9, 2'b00, "R1");
        go(1'b0, SEL_ON, 1'b0, 6'd9, 2'b00, "R1");
        flush("R1");

        // R10: write then read of the same word next cycle, every mask
        for (int m = 0; m < 4; m++) begin
            go(1'b0, SEL_ON, 1'b1, AW'(m + 20), LN'(m), "R10");
            go(1'b0, SEL_ON, 1'b0, AW'(m + 20), 2'b00, "R10");
            go(1'b0, SEL_ON, 1'b1, AW'(m + 20), LN'(3 - m), "R10");
            go(1'b0, SEL_ON, 1'b0, AW'(m + 20), 2'b00, "R10");
        end
        flush("R10");

        // R5: aborts leave memory unchanged
        go(1'b0, SEL_ON, 1'b1, 6'd30, 2'b11, "R5");
        go(1'b1, SEL_ON, 1'b0, 6'd0, 2'b11, "R5");
        go(1'b0, SEL_ON, 1'b0, 6'd30, 2'b00, "R5");
        go(1'b1, SEL_ON, 1'b0, 6'd0, 2'b00, "R5");
        flush("R5");

        // R6: bursts in both orders from every start offset, six beats to wrap
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                ilv = md[0];
                go(1'b0, SEL_ON, 1'b1, AW'(40 + s), 2'b00, "R6");
                for (int k = 0; k < 5; k++) go(1'b1, SEL_ON, 1'b1, '0, LN'(k), "R6");
                go(1'b0, SEL_ON, 1'b0, AW'(40 + s), 2'b00, "R6");
                for (int k = 0; k < 5; k++) go(1'b1, SEL_ON, 1'b1, '0, 2'b00, "R6");
            end
        end
        ilv = 1'b0;
        flush("R6");

        // R2: read and write with stalls between beats
        go(1'b0, SEL_ON, 1'b0, 6'd3, 2'b00, "R2");
        ce_n = 1'b1;
        for (int k = 0; k < 3; k++) go(1'b0, SEL_ON, 1'b1, 6'd3, 2'b00, "R2");
        ce_n = 1'b0;
        go(1'b0, SEL_ON, 1'b1, 6'd3, 2'b10, "R2");
        ce_n = 1'b1;
        go(1'b0, 3'b110, 1'b0, '0, '1, "R2");
        ce_n = 1'b0;
        go(1'b0, 3'b110, 1'b0, '0, '1, "R2");
        ce_n = 1'b1;
        go(1'b0, SEL_ON, 1'b0, '0, '1, "R2");
        ce_n = 1'b0;
        go(1'b0, SEL_ON, 1'b0, 6'd3, 2'b00, "R2");
        flush("R2");

        // R8: output enable acts without a clock
        go(1'b0, SEL_ON, 1'b0, 6'd12, 2'b00, "R8");
        go(1'b0, 3'b110, 1'b0, '0, '1, "R8");
        go(1'b0, 3'b110, 1'b0, '0, '1, "R8");
        oe_n = 1'b1;
        #0.5;
        check("R8", "rdata_en oe high", {31'd0, rdata_en}, 32'd0);
        oe_n = 1'b0;
        #0.5;
        check("R8", "rdata_en oe low", {31'd0, rdata_en}, 32'd1);
        check("R8", "rdata", {16'd0, rdata}, {16'd0, ref_mem[12]});
        oe_n = 1'b1;
        go(1'b0, SEL_ON, 1'b0, 6'd13, 2'b00, "R8");
        go(1'b0, 3'b110, 1'b0, '0, '1, "R8");
        go(1'b0, 3'b110, 1'b0, '0, '1, "R8");
        oe_n = 1'b0;
        #0.5;
        check("R8", "dummy read data", {16'd0, rdata}, {16'd0, ref_mem[13]});
        flush("R8");

        // R9: sleep ignores commands two edges after request, contents kept
        go(1'b0, SEL_ON, 1'b0, 6'd50, 2'b00, "R9");
        slp = 1'b1;
        for (int k = 0; k < 6; k++) go(1'b0, SEL_ON, 1'b1, AW'(50 + k), 2'b00, "R9");
        slp = 1'b0;
        for (int k = 0; k < 3; k++) go(1'b0, SEL_ON, 1'b1, AW'(56 + k), 2'b00, "R9");
        for (int k = 0; k < 10; k++) go(1'b0, SEL_ON, 1'b0, AW'(50 + k), 2'b00, "R9");
        flush("R9");

        // R11: random back-to-back mix with stalls, bursts and deselects
        for (int i = 0; i < 3000; i++) begin
            ce_n = (($urandom % 5) == 0);
            oe_n = (($urandom % 8) == 0);
            ilv  = 1'($urandom);
            go(1'(($urandom % 5) < 2),
               (($urandom % 7) == 0) ? 3'($urandom) : SEL_ON,
               1'($urandom), AW'($urandom), LN'($urandom), "R11");
        end
        ce_n = 1'b0;
        oe_n = 1'b0;
        flush("R11");
        for (int a = 0; a < 64; a++) go(1'b0, SEL_ON, 1'b0, AW'(a), 2'b00, "R11");
        flush("R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule